// File: doc/BRIEF.md
# AUX Request Register Front End

This block gives a host a small byte-wide register window for building a single DisplayPort AUX request and launching it toward an abstract link engine. The host programs a 20-bit transaction address and a 4-bit request code, sets the payload length, and loads outgoing bytes into a transmit FIFO. It then sets a start bit. The block presents the request to the link side with a valid/ready handshake and streams the queued bytes out.

The link side answers with a stream of reply bytes followed by a completion strobe that carries a 3-bit reply class. Reply bytes go into a receive FIFO in arrival order. The host reads a status byte that packs the reply class together with the number of bytes that were stored, and then drains the receive FIFO one byte per read. If no completion arrives within a fixed number of cycles after the request is accepted, the block closes the transaction itself with the timeout class. A key value written to a configuration register flushes the channel.

Top module: `aux_req_frontend`

## Requirements
- R1: The address bytes sit at offsets 0x00 (bits 7:0), 0x01 (bits 15:8) and 0x02; offset 0x02 holds the request code in bits 7:4 and address bits 19:16 in bits 3:0. All three read back as written, and link_addr/link_cmd show the assembled values.
- R2: Offset 0x03 is the length register: bits 3:0 hold the byte count minus one and bit 7 flags a request with no payload. It reads back those bits (bits 6:4 read 0). link_len is 0 when bit 7 is set and otherwise bits 3:0 plus one.
- R3: Each write to offset 0x04 pushes one byte into a 16-entry transmit FIFO; the bytes leave on tx_data in write order while a transaction is active. A write to a full FIFO is dropped.
- R4: Writing a value with bit 0 set to offset 0x06 while idle starts a transaction: bit 0 of offset 0x06 reads 1 from the next cycle, link_req_valid rises and stays high until link_req_ready, and bit 0 reads 0 again once the transaction completes.
- R5: Offset 0x07 reads {class[2:0], count[4:0]} after completion, where class is the rsp_class value given with rsp_done (3 means ACK) and count is the number of reply bytes stored; reply bytes are read from offset 0x05 in arrival order.
- R6: If rsp_done does not arrive within TIMEOUT_CYCLES cycles after link_req_ready is accepted, the transaction ends with class 7 and bit 0 of offset 0x06 clears.
- R7: While a transaction is active, writes to offsets 0x00-0x04 and 0x06 are ignored.
- R8: A read of offset 0x05 pops one byte; when the receive FIFO is empty it returns 0x00 and changes no state.
- R9: Writing 0xFF to offset 0x08 empties both FIFOs, clears the status register to 0x00 and abandons any active transaction; any other value written there has no effect.
- R10: Starting a transaction empties the receive FIFO and sets the status register to 0x00.
- R11: After reset all registers read 0x00, link_req_valid and tx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Host register offset |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rd | input | 1 | Host read strobe (pops the receive FIFO at offset 0x05) |
| reg_rdata | output | 8 | Host read data for reg_addr |
| link_req_valid | output | 1 | Request offered to the link engine |
| link_req_ready | input | 1 | Link engine takes the request |
| link_addr | output | 20 | Transaction address |
| link_cmd | output | 4 | Request code |
| link_len | output | 5 | Payload byte count, 0 for no payload |
| tx_valid | output | 1 | Outgoing payload byte available |
| tx_ready | input | 1 | Link engine takes the payload byte |
| tx_data | output | 8 | Outgoing payload byte |
| rsp_valid | input | 1 | Reply byte strobe |
| rsp_data | input | 8 | Reply byte |
| rsp_done | input | 1 | Reply complete strobe |
| rsp_class | input | 3 | Reply class given with rsp_done |

## Verification
The bench fills the transmit FIFO past its sixteen entries; a design that kept the seventeenth byte, or overwrote the oldest, would put a byte on tx_data that the scoreboard never queued. It withholds the completion to force a timeout and checks the block is still busy midway, catching a counter that ends early or never ends. It reads the receive FIFO past empty and rereads status, so a design that popped garbage or moved a pointer would return a nonzero byte or misorder the next transaction. It also writes the address registers during an active transaction and writes a non-key value to the configuration register, which a design with loose decode would take as a change.

// File: rtl/aux_fe_pkg.sv
package aux_fe_pkg;
  localparam logic [7:0] OFF_ADDR0 = 8'h00;
  localparam logic [7:0] OFF_ADDR1 = 8'h01;
  localparam logic [7:0] OFF_ADDR2 = 8'h02;
  localparam logic [7:0] OFF_LEN   = 8'h03;
  localparam logic [7:0] OFF_WDATA = 8'h04;
  localparam logic [7:0] OFF_RDATA = 8'h05;
  localparam logic [7:0] OFF_CTRL  = 8'h06;
  localparam logic [7:0] OFF_STAT  = 8'h07;
  localparam logic [7:0] OFF_CFG   = 8'h08;

  localparam logic [7:0] CFG_FLUSH_KEY = 8'hFF;
  localparam logic [2:0] CLASS_TIMEOUT = 3'd7;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_REQ  = 2'd1,
    TX_WAIT = 2'd2
  } txn_state_e;
endpackage

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp, wp_d, rp_d;
  logic [CW-1:0]    cnt, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_comb begin
    wp_d  = wp;
    rp_d  = rp;
    cnt_d = cnt;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp == LAST) ? '0 : wp + AW'(1);
      if (do_pop)  rp_d = (rp == LAST) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt + CW'(1);
        2'b01:   cnt_d = cnt - CW'(1);
        default: cnt_d = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_d;
      rp  <= rp_d;
      cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  // R3: a push into a full FIFO leaves it full and drops the byte
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);

  // R8: a pop of an empty FIFO leaves it empty
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);

  // R9: a flush always leaves the FIFO empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/aux_txn_ctrl.sv
module aux_txn_ctrl
  import aux_fe_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       req_ready,
  input  logic       rsp_done,
  input  logic [2:0] rsp_class,
  output logic       busy,
  output logic       req_valid,
  output logic       accept_rsp,
  output logic       done,
  output logic [2:0] done_class
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYCLES - 1);

  txn_state_e    state, state_d;
  logic [TW-1:0] timer, timer_d;

  always_comb begin
    state_d    = state;
    timer_d    = timer;
    done       = 1'b0;
    done_class = rsp_class;
    case (state)
      TX_IDLE: if (start) state_d = TX_REQ;
      TX_REQ: begin
        if (req_ready) begin
          state_d = TX_WAIT;
          timer_d = '0;
        end
      end
      TX_WAIT: begin
        if (rsp_done) begin
          done    = 1'b1;
          state_d = TX_IDLE;
        end else if (timer == LIMIT) begin
          done       = 1'b1;
          done_class = CLASS_TIMEOUT;
          state_d    = TX_IDLE;
        end else begin
          timer_d = timer + TW'(1);
        end
      end
      default: state_d = TX_IDLE;
    endcase
    if (abort) begin
      state_d = TX_IDLE;
      timer_d = '0;
      done    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      timer <= '0;
    end else begin
      state <= state_d;
      timer <= timer_d;
    end
  end

  assign busy       = (state != TX_IDLE);
  assign req_valid  = (state == TX_REQ);
  assign accept_rsp = (state == TX_WAIT);

  // R4: an offered request is held until the link takes it
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !abort) |=> req_valid);

  // R4: completion returns the controller to idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R6: the wait counter never passes the timeout window
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_rsp |-> (timer < TW'(TIMEOUT_CYCLES)));
endmodule

// File: rtl/aux_req_frontend.sv
module aux_req_frontend
  import aux_fe_pkg::*;
#(
  parameter int FIFO_DEPTH     = 16,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  output logic        link_req_valid,
  input  logic        link_req_ready,
  output logic [19:0] link_addr,
  output logic [3:0]  link_cmd,
  output logic [4:0]  link_len,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_data,
  input  logic        rsp_done,
  input  logic [2:0]  rsp_class
);
  localparam int CNTW = 5;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  logic [7:0]      addr_lo, addr_mid, addr_hi;
  logic            len_nopay;
  logic [3:0]      len_m1;
  logic [7:0]      status_q, status_d;
  logic [CNTW-1:0] rx_cnt, rx_cnt_d;

  logic busy, req_valid, accept_rsp, done;
  logic [2:0] done_class;
  logic start, chan_clear, clear_rx;
  logic we_a0, we_a1, we_a2, we_len;
  logic tx_push, tx_pop, tx_empty, tx_full;
  logic rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0] rx_head;
  logic cnt_en, stat_en;

  // write decode
  assign chan_clear = reg_wr && (reg_addr == OFF_CFG) && (reg_wdata == CFG_FLUSH_KEY);
  assign start      = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[0] && !busy;
  assign we_a0      = reg_wr && (reg_addr == OFF_ADDR0) && !busy;
  assign we_a1      = reg_wr && (reg_addr == OFF_ADDR1) && !busy;
  assign we_a2      = reg_wr && (reg_addr == OFF_ADDR2) && !busy;
  assign we_len     = reg_wr && (reg_addr == OFF_LEN) && !busy;
  assign tx_push    = reg_wr && (reg_addr == OFF_WDATA) && !busy;
  assign tx_pop     = tx_valid && tx_ready;
  assign rx_push    = rsp_valid && accept_rsp && !rx_full;
  assign rx_pop     = reg_rd && (reg_addr == OFF_RDATA);
  assign clear_rx   = chan_clear || start;

  aux_txn_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .start      (start),
    .abort      (chan_clear),
    .req_ready  (link_req_ready),
    .rsp_done   (rsp_done),
    .rsp_class  (rsp_class),
    .busy       (busy),
    .req_valid  (req_valid),
    .accept_rsp (accept_rsp),
    .done       (done),
    .done_class (done_class)
  );

  aux_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk   (clk),
    .rst_n (srst_n),
    .flush (chan_clear),
    .push  (tx_push),
    .din   (reg_wdata),
    .pop   (tx_pop),
    .dout  (tx_data),
    .empty (tx_empty),
    .full  (tx_full)
  );

  aux_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk   (clk),
    .rst_n (srst_n),
    .flush (clear_rx),
    .push  (rx_push),
    .din   (rsp_data),
    .pop   (rx_pop),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );

  // next-state for count and status
  always_comb begin
    rx_cnt_d = rx_cnt;
    status_d = status_q;
    if (clear_rx) begin
      rx_cnt_d = '0;
      status_d = 8'h00;
    end else begin
      if (rx_push) rx_cnt_d = rx_cnt + CNTW'(1);
      if (done)    status_d = {done_class, rx_cnt_d};
    end
  end
  assign cnt_en  = clear_rx || rx_push;
  assign stat_en = clear_rx || done;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_lo   <= 8'h00;
      addr_mid  <= 8'h00;
      addr_hi   <= 8'h00;
      len_nopay <= 1'b0;
      len_m1    <= 4'h0;
      rx_cnt    <= '0;
      status_q  <= 8'h00;
    end else begin
      if (we_a0) addr_lo  <= reg_wdata;
      if (we_a1) addr_mid <= reg_wdata;
      if (we_a2) addr_hi  <= reg_wdata;
      if (we_len) begin
        len_nopay <= reg_wdata[7];
        len_m1    <= reg_wdata[3:0];
      end
      if (cnt_en)  rx_cnt   <= rx_cnt_d;
      if (stat_en) status_q <= status_d;
    end
  end

  // link side
  assign link_req_valid = req_valid;
  assign link_addr      = {addr_hi[3:0], addr_mid, addr_lo};
  assign link_cmd       = addr_hi[7:4];
  assign link_len       = len_nopay ? 5'd0 : ({1'b0, len_m1} + 5'd1);
  assign tx_valid       = busy && !tx_empty;

  // host read mux
  always_comb begin
    case (reg_addr)
      OFF_ADDR0: reg_rdata = addr_lo;
      OFF_ADDR1: reg_rdata = addr_mid;
      OFF_ADDR2: reg_rdata = addr_hi;
      OFF_LEN:   reg_rdata = {len_nopay, 3'b000, len_m1};
      OFF_RDATA: reg_rdata = rx_empty ? 8'h00 : rx_head;
      OFF_CTRL:  reg_rdata = {7'b0, busy};
      OFF_STAT:  reg_rdata = status_q;
      default:   reg_rdata = 8'h00;
    endcase
  end

  // R7: address registers hold while a transaction is active
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && reg_wr && (reg_addr == OFF_ADDR0)) |=> $stable(addr_lo));

  // R8: an empty receive FIFO reads as zero on the host port
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_empty && (reg_addr == OFF_RDATA)) |-> (reg_rdata == 8'h00));

  // R5: the stored byte count never exceeds the FIFO size
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!srst_n)
    rx_cnt <= CNTW'(FIFO_DEPTH));
endmodule

// File: tb/aux_req_frontend_test.sv
module aux_req_frontend_test;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        link_req_valid;
  logic        link_req_ready = 1'b0;
  logic [19:0] link_addr;
  logic [3:0]  link_cmd;
  logic [4:0]  link_len;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic        rsp_done = 1'b0;
  logic [2:0]  rsp_class = 3'd0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  aux_req_frontend #(.FIFO_DEPTH(16), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .link_req_valid(link_req_valid), .link_req_ready(link_req_ready),
    .link_addr(link_addr), .link_cmd(link_cmd), .link_len(link_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_done(rsp_done), .rsp_class(rsp_class)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every payload byte on the link must match the queue
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 actual=%0h expected=none (unexpected payload byte)", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          bad++;
          $display("FAIL R3 actual=%0h expected=%0h", tx_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // driver: queue the expected byte and load it into the transmit FIFO
  task automatic send_byte(input logic [7:0] d, input bit expect_out);
    if (expect_out) exp_q.push_back(d);
    wr(8'h04, d);
  endtask

  task automatic link_accept();
    while (!link_req_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    link_req_ready = 1'b1;
    @(negedge clk);
    link_req_ready = 1'b0;
  endtask

  task automatic reply_byte(input logic [7:0] b);
    rsp_valid = 1'b1; rsp_data = b;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic reply_done(input logic [2:0] c);
    rsp_done = 1'b1; rsp_class = c;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(8'h07, d); check("R11 status", d, 8'h00);
    rd(8'h06, d); check("R11 ctrl", d, 8'h00);
    rd(8'h05, d); check("R11 rdata", d, 8'h00);
    check("R11 req_valid", link_req_valid, 1'b0);
    check("R11 tx_valid", tx_valid, 1'b0);

    // R1 address assembly
    wr(8'h00, 8'h34); wr(8'h01, 8'h12); wr(8'h02, 8'h8A);
    rd(8'h00, d); check("R1 addr0", d, 8'h34);
    rd(8'h02, d); check("R1 addr2", d, 8'h8A);
    check("R1 link_addr", link_addr, 20'hA1234);
    check("R1 link_cmd", link_cmd, 4'h8);

    // R2 length encoding
    wr(8'h03, 8'h80);
    rd(8'h03, d); check("R2 len nopay rb", d, 8'h80);
    check("R2 len nopay", link_len, 5'd0);
    wr(8'h03, 8'h7F);
    rd(8'h03, d); check("R2 len rb", d, 8'h0F);
    check("R2 len 16", link_len, 5'd16);
    wr(8'h03, 8'h03);
    check("R2 len 4", link_len, 5'd4);

    // R3/R4/R5 write transaction with four bytes
    send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1); send_byte(8'h44, 1);
    wr(8'h06, 8'h01);
    rd(8'h06, d); check("R4 busy set", d, 8'h01);
    check("R4 req_valid", link_req_valid, 1'b1);
    // R7 writes during a transaction
    wr(8'h00, 8'hEE); wr(8'h03, 8'h85); send_byte(8'h99, 0);
    link_accept();
    repeat (3) @(negedge clk);
    reply_done(3'd3);
    rd(8'h06, d); check("R4 busy clear", d, 8'h00);
    rd(8'h07, d); check("R5 ack status", d, 8'h60);
    check("R3 all bytes out", exp_q.size(), 0);
    rd(8'h00, d); check("R7 addr0 held", d, 8'h34);
    rd(8'h03, d); check("R7 len held", d, 8'h03);

    // R5/R8 read transaction
    wr(8'h02, 8'h9A); wr(8'h03, 8'h02);
    wr(8'h06, 8'h01);
    link_accept();
    reply_byte(8'hA1); reply_byte(8'hB2); reply_byte(8'hC3);
    reply_done(3'd3);
    rd(8'h07, d); check("R5 read status", d, 8'h63);
    rd(8'h05, d); check("R5 byte0", d, 8'hA1);
    rd(8'h05, d); check("R5 byte1", d, 8'hB2);
    rd(8'h05, d); check("R5 byte2", d, 8'hC3);
    rd(8'h05, d); check("R8 empty read", d, 8'h00);
    rd(8'h05, d); check("R8 empty again", d, 8'h00);
    rd(8'h07, d); check("R8 status kept", d, 8'h63);

    // R5 native defer, no data
    wr(8'h06, 8'h01);
    link_accept();
    reply_done(3'd2);
    rd(8'h07, d); check("R5 defer status", d, 8'h40);

    // R6 timeout
    wr(8'h06, 8'h01);
    link_accept();
    repeat (TMO - 10) @(negedge clk);
    rd(8'h06, d); check("R6 still busy", d, 8'h01);
    repeat (20) @(negedge clk);
    rd(8'h06, d); check("R6 busy cleared", d, 8'h00);
    rd(8'h07, d); check("R6 timeout status", d, 8'hE0);

    // R3 overflow and full-size reply, class 5
    for (int i = 0; i < 17; i++) send_byte(8'(8'h50 + i), (i < 16));
    wr(8'h06, 8'h01);
    link_accept();
    for (int i = 0; i < 16; i++) reply_byte(8'(8'hC0 + i));
    reply_done(3'd5);
    check("R3 sixteen out", exp_q.size(), 0);
    rd(8'h07, d); check("R5 full status", d, 8'hB0);
    rd(8'h05, d); check("R5 full byte0", d, 8'hC0);

    // R9 non-key value has no effect, key flushes
    wr(8'h08, 8'h12);
    rd(8'h07, d); check("R9 non-key status", d, 8'hB0);
    rd(8'h05, d); check("R9 non-key rdata", d, 8'hC1);
    send_byte(8'h77, 0);
    wr(8'h08, 8'hFF);
    rd(8'h07, d); check("R9 status cleared", d, 8'h00);
    rd(8'h05, d); check("R9 rx flushed", d, 8'h00);

    // R10 start flushes stale bytes; tx flushed by R9 (monitor flags any leftover)
    wr(8'h06, 8'h01);
    rd(8'h07, d); check("R10 status zero", d, 8'h00);
    link_accept();
    reply_byte(8'h5A);
    reply_done(3'd3);
    rd(8'h07, d); check("R10 count one", d, 8'h61);
    rd(8'h05, d); check("R10 fresh byte", d, 8'h5A);

    // R9 abort of an active transaction
    wr(8'h06, 8'h01);
    wr(8'h08, 8'hFF);
    rd(8'h06, d); check("R9 abort busy", d, 8'h00);
    check("R9 abort req", link_req_valid, 1'b0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule